// File: doc/BRIEF.md
# Variable-Rate Sample Request Pacer

This block sits beside an audio serial link that carries one frame every 48 kHz period. For every frame it decides whether the playback side needs a fresh sample from the controller and whether the capture side has a fresh sample to hand over. Each direction holds its own 16-bit rate in hertz. When variable-rate operation is enabled, a per-direction integer accumulator adds that rate once per frame. When the running sum reaches the 48000 frame rate, the block takes 48000 off and marks the frame as a sample event. Over any window of 48000 frames, the number of events then equals the rate exactly.

The link logic pulses `frame_stb` once per frame. In the cycle after each strobe, the block presents the frame decision. The playback request bits for the left and right slots are active low: 0 means the controller must send a valid sample in the next frame, and 1 means it must not. The capture-valid tag bits for left and right are active high. These levels stay constant until the next strobe. A one-cycle event pulse per direction marks the same decision.

Rates are written through a plain configuration strobe with a direction select and read back on dedicated outputs. There is no streaming data path, so no valid/ready handshake and no back-pressure exists at this edge.

Top module: `sample_pacer`

## Requirements
- R1: After reset, both rate outputs read 48000 (BB80h), both request bits read 1, both capture-valid bits read 0, and both event pulses read 0.
- R2: While `vra_en` is 0, every frame strobe is a sample event in both directions, whatever rates are programmed.
- R3: While `vra_en` is 1, a direction programmed to rate R (4000..48000) gives exactly R events over 48000 consecutive frames counted from the rate write. This is checked for 8000 (1F40h), 11025 (2B11h), 44100 (AC44h) and 48000.
- R4: Playback and capture rates are independent: a write with `cfg_sel`=0 changes only the playback rate and pacing, and a write with `cfg_sel`=1 changes only the capture rate and pacing.
- R5: A stored rate below 4000 is paced as 4000, so the first event after the write falls on frame 12. The readback shows the raw written value.
- R6: A stored rate above 48000 is paced as 48000, so every frame is an event.
- R7: A rate write clears that direction's accumulator, so the first event after the write falls on frame ceil(48000/R), for example frame 2 for 44100.
- R8: After a playback event frame, both `play_req_l_n` and `play_req_r_n` are 0, and after a non-event frame both are 1. After a capture event frame, both `cap_vld_l` and `cap_vld_r` are 1, and after a non-event frame both are 0.
- R9: The request and valid bits change only in the cycle after a frame strobe and hold between strobes. Each event pulse is high only in the cycle after a strobe.
- R10: A rate write to a direction in the same cycle as a frame strobe makes that frame a non-event for that direction. The other direction is evaluated normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One pulse per link frame |
| vra_en | input | 1 | 1 = programmed rates, 0 = every frame is an event |
| cfg_wr | input | 1 | Rate write strobe |
| cfg_sel | input | 1 | Write target: 0 playback, 1 capture |
| cfg_data | input | 16 | Rate in hertz to write |
| play_rate_q | output | 16 | Stored playback rate |
| cap_rate_q | output | 16 | Stored capture rate |
| play_req_l_n | output | 1 | Left playback slot request, active low |
| play_req_r_n | output | 1 | Right playback slot request, active low |
| cap_vld_l | output | 1 | Left capture sample valid |
| cap_vld_r | output | 1 | Right capture sample valid |
| play_evt | output | 1 | Playback event pulse, cycle after strobe |
| cap_evt | output | 1 | Capture event pulse, cycle after strobe |

## Verification
The checker watches every cycle for the local properties. It checks that events appear only after a strobe and that the frame bits hold between strobes. It also checks that fixed-rate mode and an over-range rate produce an event on every frame, and that a write suppresses the event of a coinciding strobe.

The long-run properties can only be shown by the bench's directed scenarios. These are the exact event count over 48000 frames, the frame index of the first event after a write, the clamp at the low end, and the independence of the two directions.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int RATE_W   = 16;
  localparam int FRAME_HZ = 48000;
  localparam int MIN_HZ   = 4000;
  localparam int MAX_HZ   = 48000;
  localparam int NDIR     = 2;

  typedef enum logic {
    DIR_PLAY = 1'b0,
    DIR_CAP  = 1'b1
  } dir_e;
endpackage

// File: rtl/rate_store.sv
module rate_store #(
  parameter int RATE_W    = pacer_pkg::RATE_W,
  parameter int RESET_HZ  = pacer_pkg::FRAME_HZ,
  parameter int MIN_HZ    = pacer_pkg::MIN_HZ,
  parameter int MAX_HZ    = pacer_pkg::MAX_HZ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [RATE_W-1:0] din,
  output logic [RATE_W-1:0] rate_q,
  output logic [RATE_W-1:0] rate_eff
);
  localparam logic [RATE_W-1:0] LO  = RATE_W'(MIN_HZ);
  localparam logic [RATE_W-1:0] HI  = RATE_W'(MAX_HZ);
  localparam logic [RATE_W-1:0] RST = RATE_W'(RESET_HZ);

  always_ff @(posedge clk) begin
    if (!rst_n)  rate_q <= RST;
    else if (wr) rate_q <= din;
  end

  // clamp applied on use; storage keeps the raw value for readback
  always_comb begin
    if (rate_q < LO)      rate_eff = LO;
    else if (rate_q > HI) rate_eff = HI;
    else                  rate_eff = rate_q;
  end
endmodule

// File: rtl/frame_accum.sv
module frame_accum #(
  parameter int RATE_W   = pacer_pkg::RATE_W,
  parameter int FRAME_HZ = pacer_pkg::FRAME_HZ,
  localparam int ACC_W   = $clog2(2 * FRAME_HZ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              clr,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  output logic              hit_frame,
  output logic              hit_pulse
);
  localparam logic [ACC_W-1:0] WRAP = ACC_W'(FRAME_HZ);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;
  logic             reach;

  assign sum   = acc + ACC_W'(rate);
  assign reach = (sum >= WRAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      hit_frame <= 1'b0;
      hit_pulse <= 1'b0;
    end else begin
      hit_pulse <= 1'b0;
      if (clr) begin
        acc <= '0;
        if (stb) hit_frame <= 1'b0;
      end else if (stb) begin
        if (!en) begin
          acc       <= '0;
          hit_frame <= 1'b1;
          hit_pulse <= 1'b1;
        end else if (reach) begin
          acc       <= sum - WRAP;
          hit_frame <= 1'b1;
          hit_pulse <= 1'b1;
        end else begin
          acc       <= sum;
          hit_frame <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sample_pacer.sv
module sample_pacer
  import pacer_pkg::*;
#(
  parameter int RW       = pacer_pkg::RATE_W,
  parameter int FRAME_RT = pacer_pkg::FRAME_HZ,
  parameter int LO_RT    = pacer_pkg::MIN_HZ,
  parameter int HI_RT    = pacer_pkg::MAX_HZ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic          vra_en,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [RW-1:0] cfg_data,
  output logic [RW-1:0] play_rate_q,
  output logic [RW-1:0] cap_rate_q,
  output logic          play_req_l_n,
  output logic          play_req_r_n,
  output logic          cap_vld_l,
  output logic          cap_vld_r,
  output logic          play_evt,
  output logic          cap_evt
);
  logic [RW-1:0] rate_q   [NDIR];
  logic [RW-1:0] rate_eff [NDIR];
  logic          hit_frm  [NDIR];
  logic          hit_pls  [NDIR];

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic wr_d;
    assign wr_d = cfg_wr && (cfg_sel == 1'(d));

    rate_store #(
      .RATE_W(RW), .RESET_HZ(FRAME_RT), .MIN_HZ(LO_RT), .MAX_HZ(HI_RT)
    ) u_rate (
      .clk(clk), .rst_n(rst_n), .wr(wr_d), .din(cfg_data),
      .rate_q(rate_q[d]), .rate_eff(rate_eff[d])
    );

    frame_accum #(
      .RATE_W(RW), .FRAME_HZ(FRAME_RT)
    ) u_acc (
      .clk(clk), .rst_n(rst_n), .stb(frame_stb), .clr(wr_d), .en(vra_en),
      .rate(rate_eff[d]), .hit_frame(hit_frm[d]), .hit_pulse(hit_pls[d])
    );
  end

  assign play_rate_q  = rate_q[DIR_PLAY];
  assign cap_rate_q   = rate_q[DIR_CAP];
  assign play_req_l_n = ~hit_frm[DIR_PLAY];
  assign play_req_r_n = ~hit_frm[DIR_PLAY];
  assign cap_vld_l    = hit_frm[DIR_CAP];
  assign cap_vld_r    = hit_frm[DIR_CAP];
  assign play_evt     = hit_pls[DIR_PLAY];
  assign cap_evt      = hit_pls[DIR_CAP];
endmodule

// File: rtl/pacer_checker.sv
module pacer_checker #(
  parameter int RW    = 16,
  parameter int HI_RT = 48000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_stb,
  input logic          vra_en,
  input logic          cfg_wr,
  input logic          cfg_sel,
  input logic [RW-1:0] play_rate_q,
  input logic          play_req_l_n,
  input logic          cap_vld_l,
  input logic          play_evt,
  input logic          cap_evt
);
  AST_EVT_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (play_evt || cap_evt) |-> $past(frame_stb)); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_stb) |-> ($stable(play_req_l_n) && $stable(cap_vld_l))); // R9

  AST_FIXED_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !vra_en && !cfg_wr) |=> (play_evt && cap_evt)); // R2

  AST_HIGH_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && vra_en && !cfg_wr && play_rate_q >= RW'(HI_RT)) |=> play_evt); // R6

  AST_WRITE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && cfg_wr && !cfg_sel) |=> (!play_evt && play_req_l_n)); // R10
endmodule

bind sample_pacer pacer_checker #(.RW(RW), .HI_RT(HI_RT)) u_pacer_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .vra_en(vra_en),
  .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .play_rate_q(play_rate_q),
  .play_req_l_n(play_req_l_n), .cap_vld_l(cap_vld_l),
  .play_evt(play_evt), .cap_evt(cap_evt)
);

// File: tb/test_sample_pacer.sv
module test_sample_pacer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_stb = 1'b0;
  logic        vra_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_data = '0;
  logic [15:0] play_rate_q, cap_rate_q;
  logic        play_req_l_n, play_req_r_n, cap_vld_l, cap_vld_r, play_evt, cap_evt;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sample_pacer i_sample_pacer (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .vra_en(vra_en),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .play_rate_q(play_rate_q), .cap_rate_q(cap_rate_q),
    .play_req_l_n(play_req_l_n), .play_req_r_n(play_req_r_n),
    .cap_vld_l(cap_vld_l), .cap_vld_r(cap_vld_r),
    .play_evt(play_evt), .cap_evt(cap_evt)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr_rate(bit sel, int hz);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = 16'(hz);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_frames(int n, output int pc, output int cc);
    pc = 0; cc = 0;
    frame_stb = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pc += int'(play_evt);
      cc += int'(cap_evt);
    end
    frame_stb = 1'b0;
  endtask

  task automatic first_hit(int maxn, output int pf, output int cf);
    pf = 0; cf = 0;
    frame_stb = 1'b1;
    for (int i = 1; i <= maxn; i++) begin
      @(negedge clk);
      if (play_evt && pf == 0) pf = i;
      if (cap_evt && cf == 0) cf = i;
    end
    frame_stb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 play rate", play_rate_q, 48000);
    chk("R1 cap rate", cap_rate_q, 48000);
    chk("R1 req left", play_req_l_n, 1);
    chk("R1 req right", play_req_r_n, 1);
    chk("R1 cap valid", cap_vld_l + cap_vld_r, 0);
    chk("R1 events", play_evt + cap_evt, 0);
  endtask

  task automatic t_fixed();
    int pc, cc;
    vra_en = 1'b0;
    wr_rate(0, 8000);
    wr_rate(1, 11025);
    run_frames(5, pc, cc);
    chk("R2 play count", pc, 5);
    chk("R2 cap count", cc, 5);
    chk("R8 req after event", play_req_l_n + play_req_r_n, 0);
    chk("R8 cap valid after event", cap_vld_l + cap_vld_r, 2);
    repeat (3) @(negedge clk);
    chk("R9 no pulse idle", play_evt + cap_evt, 0);
    chk("R9 req held", play_req_l_n, 0);
  endtask

  task automatic t_count(int pr, int cr);
    int pc, cc;
    vra_en = 1'b1;
    wr_rate(0, pr);
    wr_rate(1, cr);
    run_frames(48000, pc, cc);
    chk($sformatf("R3 play %0d", pr), pc, pr);
    chk($sformatf("R3 cap %0d", cr), cc, cr);
  endtask

  task automatic t_restart();
    int pc, cc, pf, cf;
    wr_rate(0, 30000);
    wr_rate(1, 9000);
    run_frames(7, pc, cc);
    wr_rate(0, 44100);
    chk("R4 cap rate kept", cap_rate_q, 9000);
    chk("R4 play rate new", play_rate_q, 44100);
    first_hit(3, pf, cf);
    chk("R7 first play event", pf, 2);
    // capture keeps its accumulated phase: 7*9000=63000 -> acc 15000; frames 8..10
    // sums 24000,33000,42000 -> no event within 3 frames
    chk("R4 cap undisturbed", cf, 0);
  endtask

  task automatic t_clamp();
    int pc, cc, pf, cf;
    wr_rate(1, 100);
    chk("R5 raw readback", cap_rate_q, 100);
    wr_rate(0, 48000);
    first_hit(13, pf, cf);
    chk("R5 low clamp first event", cf, 12);
    wr_rate(1, 60000);
    run_frames(10, pc, cc);
    chk("R6 high clamp count", cc, 10);
  endtask

  task automatic t_polarity();
    int pc, cc;
    wr_rate(0, 24000);
    wr_rate(1, 24000);
    run_frames(1, pc, cc);
    chk("R8 req idle frame l", play_req_l_n, 1);
    chk("R8 req idle frame r", play_req_r_n, 1);
    chk("R8 cap idle frame", cap_vld_l + cap_vld_r, 0);
    run_frames(1, pc, cc);
    chk("R8 req event frame", play_req_l_n + play_req_r_n, 0);
    chk("R8 cap event frame", cap_vld_l + cap_vld_r, 2);
  endtask

  task automatic t_collide();
    wr_rate(1, 48000);
    frame_stb = 1'b1; cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_data = 16'd48000;
    @(negedge clk);
    frame_stb = 1'b0; cfg_wr = 1'b0;
    chk("R10 play no event", play_evt, 0);
    chk("R10 play req high", play_req_l_n, 1);
    chk("R10 cap evaluated", cap_evt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_count(8000, 11025);
    t_count(44100, 48000);
    t_restart();
    t_clamp();
    t_polarity();
    t_collide();
    done = 1;
    summary();
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      summary();
    end
  end
endmodule